// File: doc/BRIEF.md
# Serial-wire debug attach sequencer

This block drives the attach procedure for a debug target over a serial-wire debug link. It sits above a separate engine that handles the wire-level bits and transactions, and it gives that engine one command at a time. There are three kinds of command. A run holds the data line at one level for a number of cycles. A pattern shifts out a value least-significant bit first. A transaction is a debug-port or access-port read or write.

A connect request starts a fixed script. First comes the wire switch: line reset, switch code, line reset, then idle. Next it reads the target identification word and clears sticky errors. It then requests power-up of the debug and system domains and checks the memory access port's identity through bank 0xF of the select register. Last, it programs the access port's control word for privileged 32-bit auto-incrementing accesses. The identification word read in the script is kept on an output. A detach request powers the domains down and sends trailing idle cycles. A fault from the engine, or an identity that is not accepted, stops the script and sets the failed state.

The controller has five named states:
- IDLE: no script is running.
- ISSUE: `req_valid` is high for one cycle.
- WAIT: the sequencer waits for `eng_done`.
- LINKED: the target is attached.
- FAILED: the script has stopped.

The transitions are:
- IDLE or FAILED to ISSUE on `connect_req`, at step 0.
- LINKED to ISSUE on `detach_req`, at step 12.
- ISSUE to WAIT every time.
- WAIT to ISSUE on a clean completion, with the step advanced by one.
- WAIT to FAILED on a fault, or on a rejected identity at step 9.
- WAIT to LINKED when step 11 completes.
- WAIT to IDLE when step 13 completes.

Top module: `swd_attach_seq`

## Requirements
- R1: After reset the block is in IDLE. `req_valid`, `connected`, `failed`, `busy` and `tgt_reset` are all 0, and `idcode` is 0.
- R2: A connect request first issues a run (`req_kind`=0) with `req_level`=1 and `req_len`=LINE_RESET_LEN (50 by default).
- R3: Three commands follow, in this order:
  - a pattern (`req_kind`=1) with `req_len`=16 and `req_wdata`=0xE79E, sent LSB first;
  - another line-reset run;
  - a run with `req_level`=0 and `req_len`=2.
- R4: The next command is a transaction (`req_kind`=2) that reads the debug port (`req_ap`=0, `req_rd`=1) at address bits[3:2]=0 (`req_addr`=0). Its read data appears on `idcode` from the cycle after completion, and `idcode` clears to 0 when a connect starts.
- R5: Two debug-port writes follow. The first writes 0x0000001E at `req_addr`=0. The second writes 0xF0000001 at `req_addr`=1 (address 0x4).
- R6: The identity check has three transactions:
  - a debug-port write of 0xF0 at `req_addr`=2;
  - an access-port read at `req_addr`=3;
  - a debug-port read at `req_addr`=3.

  If the data of the last read is neither 0x24770011 nor 0x74770001, the block enters FAILED and issues nothing more.
- R7: After a good identity, the block writes 0 to the debug port at `req_addr`=2. It then writes 0x22000012 to the access port at `req_addr`=0. When that write completes, `connected` goes to 1.
- R8: An `eng_fault` that arrives with `eng_done` sends the block to FAILED from the next cycle, with no further command. FAILED holds until `connect_req`, which restarts the script at step 0.
- R9: `tgt_reset` is 1 from the first command of a connect until the control-word write completes, or until the script fails. It is 0 otherwise, including during detach.
- R10: `detach_req` in LINKED issues two commands, then returns to IDLE. The first is a debug-port write of 0 at `req_addr`=1. The second is a run with `req_level`=0 and `req_len`=8.
- R11: `req_valid` lasts one cycle. No new command is issued before `eng_done` for the previous one.
- R12: `connect_req` and `detach_req` are ignored while a script runs (`busy`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| connect_req | input | 1 | Start the attach script (IDLE or FAILED) |
| detach_req | input | 1 | Start the detach script (LINKED) |
| req_valid | output | 1 | One-cycle command strobe to the engine |
| req_kind | output | 2 | 0 run, 1 pattern, 2 transaction |
| req_level | output | 1 | Line level for a run |
| req_len | output | 8 | Cycle count for a run or pattern |
| req_ap | output | 1 | Transaction targets the access port |
| req_rd | output | 1 | Transaction is a read |
| req_addr | output | 2 | Register address bits [3:2] |
| req_wdata | output | 32 | Write data or pattern value |
| eng_done | input | 1 | Engine finished the command |
| eng_fault | input | 1 | Command failed (valid with eng_done) |
| eng_rdata | input | 32 | Read data (valid with eng_done) |
| busy | output | 1 | A script is in progress |
| connected | output | 1 | Target attached |
| failed | output | 1 | Script stopped on an error |
| tgt_reset | output | 1 | Target reset request |
| idcode | output | 32 | Captured identification word |

## Verification
A step counter that skips or repeats shows up on the command that follows. That command reaches the command port with the wrong kind, address or data in the cycle after the previous `eng_done`. A wrong state register shows up in the flags or strobe. `connected`, `failed`, `busy` or `tgt_reset` take a wrong value, or `req_valid` fires while waiting, in that same cycle. The bench's model follows every cycle, so any of these is reported within one clock of the divergence.

// File: rtl/swd_attach_pkg.sv
package swd_attach_pkg;
    localparam int LEN_W  = 8;
    localparam int STEP_W = 4;

    typedef enum logic [1:0] {
        K_RUN     = 2'd0,
        K_PATTERN = 2'd1,
        K_TXN     = 2'd2
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic             level;
        logic [LEN_W-1:0] len;
        logic             ap;
        logic             rd;
        logic [1:0]       addr;
        logic [31:0]      data;
    } cmd_t;

    localparam logic [STEP_W-1:0] S_IDCODE = 4'd4;
    localparam logic [STEP_W-1:0] S_IDCHK  = 4'd9;
    localparam logic [STEP_W-1:0] S_CSW    = 4'd11;
    localparam logic [STEP_W-1:0] S_DETACH = 4'd12;
    localparam logic [STEP_W-1:0] S_LAST   = 4'd13;

    localparam logic [15:0] SWITCH_CODE = 16'hE79E;
    localparam logic [31:0] ID_ACCEPT_A = 32'h24770011;
    localparam logic [31:0] ID_ACCEPT_B = 32'h74770001;
    localparam logic [31:0] CSW_WORD    = 32'h22000012;
endpackage

// File: rtl/swd_attach_script.sv
module swd_attach_script
    import swd_attach_pkg::*;
#(
    parameter int LINE_RESET_LEN = 50
) (
    input  logic [STEP_W-1:0] step,
    output cmd_t              cmd
);
    function automatic cmd_t run(input logic lvl, input int n);
        cmd_t c = '0;
        c.kind  = K_RUN;
        c.level = lvl;
        c.len   = LEN_W'(n);
        return c;
    endfunction

    function automatic cmd_t txn(input logic ap, input logic rd,
                                 input logic [1:0] a, input logic [31:0] d);
        cmd_t c = '0;
        c.kind = K_TXN;
        c.ap   = ap;
        c.rd   = rd;
        c.addr = a;
        c.data = d;
        return c;
    endfunction

    always_comb begin
        cmd = '0;
        case (step)
            4'd0, 4'd2: cmd = run(1'b1, LINE_RESET_LEN);
            4'd1: begin
                cmd.kind = K_PATTERN;
                cmd.len  = LEN_W'(16);
                cmd.data = {16'h0, SWITCH_CODE};
            end
            4'd3:  cmd = run(1'b0, 2);
            4'd4:  cmd = txn(1'b0, 1'b1, 2'd0, 32'h0);
            4'd5:  cmd = txn(1'b0, 1'b0, 2'd0, 32'h0000001E);
            4'd6:  cmd = txn(1'b0, 1'b0, 2'd1, 32'hF0000001);
            4'd7:  cmd = txn(1'b0, 1'b0, 2'd2, 32'h000000F0);
            4'd8:  cmd = txn(1'b1, 1'b1, 2'd3, 32'h0);
            4'd9:  cmd = txn(1'b0, 1'b1, 2'd3, 32'h0);
            4'd10: cmd = txn(1'b0, 1'b0, 2'd2, 32'h0);
            4'd11: cmd = txn(1'b1, 1'b0, 2'd0, CSW_WORD);
            4'd12: cmd = txn(1'b0, 1'b0, 2'd1, 32'h0);
            4'd13: cmd = run(1'b0, 8);
            default: cmd = '0;
        endcase
    end
endmodule

// File: rtl/swd_attach_idchk.sv
module swd_attach_idchk
    import swd_attach_pkg::*;
#(
    parameter logic [31:0] ACCEPT_A = ID_ACCEPT_A,
    parameter logic [31:0] ACCEPT_B = ID_ACCEPT_B
) (
    input  logic [31:0] value,
    output logic        match
);
    assign match = (value == ACCEPT_A) || (value == ACCEPT_B);
endmodule

// File: rtl/swd_attach_seq.sv
module swd_attach_seq
    import swd_attach_pkg::*;
#(
    parameter int LINE_RESET_LEN = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        connect_req,
    input  logic        detach_req,
    output logic        req_valid,
    output logic [1:0]  req_kind,
    output logic        req_level,
    output logic [7:0]  req_len,
    output logic        req_ap,
    output logic        req_rd,
    output logic [1:0]  req_addr,
    output logic [31:0] req_wdata,
    input  logic        eng_done,
    input  logic        eng_fault,
    input  logic [31:0] eng_rdata,
    output logic        busy,
    output logic        connected,
    output logic        failed,
    output logic        tgt_reset,
    output logic [31:0] idcode
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_WAIT, ST_LINKED, ST_FAILED
    } state_e;

    state_e            state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic [31:0]       id_q, id_d;
    cmd_t              cmd;
    logic              id_ok;

    swd_attach_script #(.LINE_RESET_LEN(LINE_RESET_LEN)) script_i (
        .step (step_q),
        .cmd  (cmd)
    );

    swd_attach_idchk idchk_i (
        .value (eng_rdata),
        .match (id_ok)
    );

    // next state
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        id_d    = id_q;
        unique case (state_q)
            ST_IDLE, ST_FAILED: begin
                if (connect_req) begin
                    state_d = ST_ISSUE;
                    step_d  = '0;
                    id_d    = '0;
                end
            end
            ST_LINKED: begin
                if (detach_req) begin
                    state_d = ST_ISSUE;
                    step_d  = S_DETACH;
                end
            end
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT: begin
                if (eng_done) begin
                    if (eng_fault) begin
                        state_d = ST_FAILED;
                    end else begin
                        if (step_q == S_IDCODE) id_d = eng_rdata;
                        if (step_q == S_IDCHK && !id_ok) begin
                            state_d = ST_FAILED;
                        end else if (step_q == S_CSW) begin
                            state_d = ST_LINKED;
                        end else if (step_q == S_LAST) begin
                            state_d = ST_IDLE;
                        end else begin
                            state_d = ST_ISSUE;
                            step_d  = step_q + STEP_W'(1);
                        end
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            id_q    <= id_d;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
        req_valid = (state_q == ST_ISSUE);
        connected = (state_q == ST_LINKED);
        failed    = (state_q == ST_FAILED);
        tgt_reset = busy && (step_q <= S_CSW);
        idcode    = id_q;
        req_kind  = cmd.kind;
        req_level = cmd.level;
        req_len   = cmd.len;
        req_ap    = cmd.ap;
        req_rd    = cmd.rd;
        req_addr  = cmd.addr;
        req_wdata = cmd.data;
    end
endmodule

// File: rtl/swd_attach_seq_chk.sv
module swd_attach_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic connect_req,
    input logic eng_done,
    input logic eng_fault,
    input logic req_valid,
    input logic busy,
    input logic connected,
    input logic failed,
    input logic tgt_reset
);
    p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    p_exclusive_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(connected && failed));

    p_fault_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !req_valid && eng_done && eng_fault) |=> (failed && !req_valid));

    p_failed_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (failed && !connect_req) |=> failed);

    p_reset_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_reset) |-> (connected || failed));

    p_quiet_when_settled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (connected || failed) |-> (!req_valid && !busy && !tgt_reset));
endmodule

bind swd_attach_seq swd_attach_seq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .connect_req (connect_req),
    .eng_done    (eng_done),
    .eng_fault   (eng_fault),
    .req_valid   (req_valid),
    .busy        (busy),
    .connected   (connected),
    .failed      (failed),
    .tgt_reset   (tgt_reset)
);

// File: tb/swd_attach_seq_tb_top.sv
module swd_attach_seq_tb_top;
    localparam logic [31:0] GOOD_A = 32'h24770011;
    localparam logic [31:0] GOOD_B = 32'h74770001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        connect_req = 1'b0, detach_req = 1'b0;
    logic        req_valid, req_level, req_ap, req_rd;
    logic [1:0]  req_kind, req_addr;
    logic [7:0]  req_len;
    logic [31:0] req_wdata;
    logic        eng_done = 1'b0, eng_fault = 1'b0;
    logic [31:0] eng_rdata = '0;
    logic        busy, connected, failed, tgt_reset;
    logic [31:0] idcode;

    swd_attach_seq dut_i (
        .clk(clk), .rst_n(rst_n), .connect_req(connect_req), .detach_req(detach_req),
        .req_valid(req_valid), .req_kind(req_kind), .req_level(req_level),
        .req_len(req_len), .req_ap(req_ap), .req_rd(req_rd), .req_addr(req_addr),
        .req_wdata(req_wdata), .eng_done(eng_done), .eng_fault(eng_fault),
        .eng_rdata(eng_rdata), .busy(busy), .connected(connected), .failed(failed),
        .tgt_reset(tgt_reset), .idcode(idcode)
    );

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // engine stand-in
    int          lat = 1, fault_idx = -1, req_count = 0, busy_cnt = 0;
    logic [31:0] id_val = GOOD_A, idc_val = 32'h0BB11477, pend_rdata = '0;
    logic        pend_fault = 1'b0;

    always @(negedge clk) begin
        eng_done  = 1'b0;
        eng_fault = 1'b0;
        if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) begin
                eng_done  = 1'b1;
                eng_fault = pend_fault;
                eng_rdata = pend_rdata;
            end
        end
        if (req_valid) begin
            busy_cnt   = lat;
            pend_fault = (req_count == fault_idx);
            req_count++;
            if (req_kind == 2'd2 && req_rd && !req_ap && req_addr == 2'd0)
                pend_rdata = idc_val;
            else if (req_kind == 2'd2 && req_rd && !req_ap && req_addr == 2'd3)
                pend_rdata = id_val;
            else
                pend_rdata = 32'h5A5A0000 + 32'(req_count);
        end
    end

    // reference model: 0 idle, 1 issue, 2 wait, 3 linked, 4 failed
    int          m_st = 0, m_step = 0;
    logic [31:0] m_id = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_step <= 0; m_id <= '0;
        end else begin
            case (m_st)
                0, 4: if (connect_req) begin m_st <= 1; m_step <= 0; m_id <= '0; end
                3: if (detach_req) begin m_st <= 1; m_step <= 12; end
                1: m_st <= 2;
                2: if (eng_done) begin
                    if (eng_fault) m_st <= 4;
                    else begin
                        if (m_step == 4) m_id <= eng_rdata;
                        if (m_step == 9 && !(eng_rdata == GOOD_A || eng_rdata == GOOD_B)) m_st <= 4;
                        else if (m_step == 11) m_st <= 3;
                        else if (m_step == 13) m_st <= 0;
                        else begin m_st <= 1; m_step <= m_step + 1; end
                    end
                end
                default: ;
            endcase
        end
    end

    function automatic string step_tag(input int s);
        if (s == 0) return "R2";
        if (s <= 3) return "R3";
        if (s == 4) return "R4";
        if (s <= 6) return "R5";
        if (s <= 9) return "R6";
        if (s <= 11) return "R7";
        return "R10";
    endfunction

    // expected command: kind, level, len, ap, rd, addr, data
    task automatic exp_cmd(input int s, output int k, output int lv, output int ln,
                           output int ap, output int rd, output int ad, output logic [31:0] d);
        k = 2; lv = 0; ln = 0; ap = 0; rd = 0; ad = 0; d = '0;
        case (s)
            0, 2: begin k = 0; lv = 1; ln = 50; end
            1:  begin k = 1; ln = 16; d = 32'h0000E79E; end
            3:  begin k = 0; ln = 2; end
            4:  begin rd = 1; end
            5:  begin d = 32'h1E; end
            6:  begin ad = 1; d = 32'hF0000001; end
            7:  begin ad = 2; d = 32'hF0; end
            8:  begin ap = 1; rd = 1; ad = 3; end
            9:  begin rd = 1; ad = 3; end
            10: begin ad = 2; end
            11: begin ap = 1; d = 32'h22000012; end
            12: begin ad = 1; end
            13: begin k = 0; ln = 8; end
            default: ;
        endcase
    endtask

    bit run_cmp = 1'b0;
    always @(negedge clk) begin
        if (run_cmp) begin
            int k, lv, ln, ap, rd, ad;
            logic [31:0] d;
            string t;
            check(req_valid == (m_st == 1), "R11", "req_valid", 32'(req_valid), 32'(m_st == 1));
            check(connected == (m_st == 3), "R7", "connected", 32'(connected), 32'(m_st == 3));
            check(failed == (m_st == 4), "R8", "failed", 32'(failed), 32'(m_st == 4));
            check(busy == (m_st == 1 || m_st == 2), "R12", "busy", 32'(busy), 32'(m_st == 1 || m_st == 2));
            check(tgt_reset == ((m_st == 1 || m_st == 2) && m_step <= 11), "R9", "tgt_reset",
                  32'(tgt_reset), 32'((m_st == 1 || m_st == 2) && m_step <= 11));
            check(idcode == m_id, "R4", "idcode", idcode, m_id);
            if (m_st == 1 && req_valid) begin
                exp_cmd(m_step, k, lv, ln, ap, rd, ad, d);
                t = step_tag(m_step);
                check(req_kind == 2'(k), t, "kind", 32'(req_kind), 32'(k));
                if (k == 0) begin
                    check(req_level == 1'(lv), t, "level", 32'(req_level), 32'(lv));
                    check(req_len == 8'(ln), t, "len", 32'(req_len), 32'(ln));
                end else if (k == 1) begin
                    check(req_len == 8'(ln), t, "len", 32'(req_len), 32'(ln));
                    check(req_wdata == d, t, "pattern", req_wdata, d);
                end else begin
                    check(req_ap == 1'(ap), t, "ap", 32'(req_ap), 32'(ap));
                    check(req_rd == 1'(rd), t, "rd", 32'(req_rd), 32'(rd));
                    check(req_addr == 2'(ad), t, "addr", 32'(req_addr), 32'(ad));
                    if (rd == 0) check(req_wdata == d, t, "wdata", req_wdata, d);
                end
            end
        end
    end

    task automatic pulse(input bit conn, input bit det);
        @(negedge clk);
        connect_req = conn;
        detach_req  = det;
        @(negedge clk);
        connect_req = 1'b0;
        detach_req  = 1'b0;
    endtask

    task automatic wait_model(input int st, input string tag);
        int n = 0;
        while (m_st != st && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(m_st == st, tag, "reach state", 32'(m_st), 32'(st));
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!req_valid && !busy && !connected && !failed && !tgt_reset, "R1", "flags at reset",
              {27'b0, req_valid, busy, connected, failed, tgt_reset}, 32'h0);
        check(idcode == 32'h0, "R1", "idcode at reset", idcode, 32'h0);
        rst_n = 1'b1;
        run_cmp = 1'b1;
        repeat (2) @(negedge clk);

        // clean attach, identity A, latency 1
        pulse(1'b1, 1'b0);
        wait_model(3, "R7");
        check(connected && idcode == 32'h0BB11477, "R4", "captured id", idcode, 32'h0BB11477);
        // R12: connect in LINKED has no effect
        pulse(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check(connected && !busy, "R12", "connect while linked", 32'(busy), 32'h0);

        // detach
        pulse(1'b0, 1'b1);
        wait_model(0, "R10");
        check(!connected && !busy, "R10", "idle after detach", 32'(connected), 32'h0);

        // identity B, longer latency, requests during run ignored
        lat = 3; id_val = GOOD_B; idc_val = 32'h2BA01477;
        pulse(1'b1, 1'b0);
        repeat (10) @(negedge clk);
        pulse(1'b1, 1'b1);
        wait_model(3, "R12");
        check(connected, "R6", "identity B accepted", 32'(connected), 32'h1);

        // bad identity
        pulse(1'b0, 1'b1);
        wait_model(0, "R10");
        id_val = 32'h12345678; lat = 2;
        pulse(1'b1, 1'b0);
        wait_model(4, "R6");
        repeat (20) @(negedge clk);
        check(failed && !req_valid, "R6", "rejected identity holds", 32'(failed), 32'h1);

        // fault at 6th command, restart from FAILED
        id_val = GOOD_A; lat = 1; fault_idx = req_count + 5;
        pulse(1'b1, 1'b0);
        wait_model(4, "R8");
        check(idcode == idc_val, "R4", "id kept after later fault", idcode, idc_val);
        fault_idx = -1;
        pulse(1'b1, 1'b0);
        wait_model(3, "R8");

        // fault during detach
        fault_idx = req_count;
        pulse(1'b0, 1'b1);
        wait_model(4, "R8");
        check(failed && !tgt_reset, "R9", "no reset on detach fault", 32'(tgt_reset), 32'h0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule